// File: doc/BRIEF.md
# Converter Result Serial Readout

This block is the output side of a delta-sigma converter. Each time the conversion pipeline finishes a sample, it raises a one-cycle done strobe with the sample and two condition inputs: overrange (positive or negative) and modulator instability. The block packs these into a 24-bit result word and holds it. It then shifts the word out to a host over a three-wire serial link: a host-driven serial clock, an active-low select, and a data line that is released (high impedance) while select is high.

The data line also carries the ready flag. While select is low and no word is waiting, the line sits high. When a word is waiting, the line drops low on a rising serial clock edge, and that low level is also the word's leading zero bit. The first falling edge after the drop is skipped. Each later falling edge presents the next bit, most significant first. After the last bit the line returns high. A conversion that finishes during a read is dropped. If select rises during a read, the word is discarded. In the free-running variant, a waiting word that has not started to shift is withdrawn shortly before the next conversion is due.

The serial clock and select are sampled in the system clock domain, so every edge action takes effect on the system clock edge that first sees the new level.

Top module: `adc_result_sport`

## Requirements
- R1: While `cs_ni` is high, `sdo_oe_o` is 0 (line released), and a waiting word is not lost. While `cs_ni` is low, `sdo_oe_o` is 1, and `sdo_o` is 1 whenever no word is being shifted.
- R2: A waiting word with `cs_ni` low drives `sdo_o` low only from the system clock edge that first sees `sclk_i` rise. With no rising edge, the line stays high.
- R3: After the line drops, the first falling serial edge leaves the line unchanged. Each later falling edge presents the next bit, so bits 23 down to 0 can be sampled just before the 24 rising edges that follow.
- R4: Word layout: bit 23 = 0, bit 22 = overrange flag, bit 21 = oscillation flag, bit 20 = 0, bits 19..0 = sample in two's complement. With `SAMPLE_W` = 16, bits 19..16 are 0 and the sample sits in bits 15..0.
- R5: A positive overrange forces the sample field to the largest positive code (0x7FFFF, or 0x7FFF for 16 bits). A negative overrange forces it to the most negative code (0x80000, or 0x8000). Positive wins if both are set.
- R6: The overrange flag reflects only the conversion that produced the word, so it clears on the first conversion without overrange.
- R7: A conversion with `mod_unstable_i` high sets the oscillation flag. The next three stable conversions still carry the flag. The fourth stable one clears it.
- R8: The falling edge after bit 0 returns `sdo_o` high, and it stays high until a new word arrives.
- R9: A done strobe during a read is ignored. The word being read is unchanged, and no new word is waiting after the read.
- R10: If `cs_ni` rises during a read, the word is discarded. No word is waiting until the next conversion.
- R11: A new conversion replaces a waiting word that has not started to shift.
- R12: With `FREE_RUN` = 1, a waiting word that has not shifted past bit 23 is withdrawn (line high) on the clock edge where `WORD_PERIOD - WITHDRAW_LEAD` cycles have passed since the last done strobe. The next conversion drops the line again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (also the free-running conversion clock) |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Host serial clock, sampled by `clk_i` |
| cs_ni | input | 1 | Active-low select from the host |
| conv_done_i | input | 1 | One-cycle strobe marking a finished conversion |
| sample_i | input | SAMPLE_W | Two's-complement conversion result |
| ovr_pos_i | input | 1 | Positive overrange for this conversion |
| ovr_neg_i | input | 1 | Negative overrange for this conversion |
| mod_unstable_i | input | 1 | Modulator found unstable for this conversion |
| sdo_o | output | 1 | Serial data / ready level |
| sdo_oe_o | output | 1 | Output enable for the data line driver |

## Verification
A wrong sequencer state shows up on the data line within one serial clock period. A spurious drop appears right after the next rising edge. A lost or extra skip edge shifts every later bit by one position, so the whole word miscompares. A stale word after a dropped or aborted read shows as a low line on the next rising edge, where the host expects high. The flag trackers only show their state inside later words, so an off-by-one in the oscillation hold count appears exactly at the fourth stable word after an unstable one.

// File: rtl/sro_pkg.sv
package sro_pkg;

   localparam int WORD_W  = 24;
   localparam int FIELD_W = 20;

   typedef struct packed {
      logic               lead_zero;
      logic               ovr_flag;
      logic               osc_flag;
      logic               pad_zero;
      logic [FIELD_W-1:0] field;
   } sro_word_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PEND  = 2'd1,
      ST_SHIFT = 2'd2
   } sro_state_e;

endpackage

// File: rtl/sro_edge_det.sv
module sro_edge_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic rise_o,
   output logic fall_o
);

   logic sig_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) sig_q <= 1'b0;
      else         sig_q <= sig_i;
   end

   assign rise_o =  sig_i & ~sig_q;
   assign fall_o = ~sig_i &  sig_q;

endmodule

// File: rtl/sro_word_fmt.sv
module sro_word_fmt
   import sro_pkg::*;
#(
   parameter int SAMPLE_W = 20
) (
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                ovr_pos_i,
   input  logic                ovr_neg_i,
   input  logic                osc_flag_i,
   output sro_word_t           word_o
);

   localparam int PAD_W = FIELD_W - SAMPLE_W;
   localparam logic [SAMPLE_W-1:0] POS_FULL = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic [SAMPLE_W-1:0] clipped;

   always_comb begin
      if (ovr_pos_i)      clipped = POS_FULL;
      else if (ovr_neg_i) clipped = NEG_FULL;
      else                clipped = sample_i;
   end

   generate
      if (PAD_W > 0) begin : g_padded
         assign word_o.field = {{PAD_W{1'b0}}, clipped};
      end else begin : g_full
         assign word_o.field = clipped;
      end
   endgenerate

   assign word_o.lead_zero = 1'b0;
   assign word_o.pad_zero  = 1'b0;
   assign word_o.ovr_flag  = ovr_pos_i | ovr_neg_i;
   assign word_o.osc_flag  = osc_flag_i;

endmodule

// File: rtl/sro_osc_track.sv
module sro_osc_track #(
   parameter int CLEAR_WORDS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic conv_i,
   input  logic unstable_i,
   output logic flag_o
);

   localparam int CNT_W = $clog2(CLEAR_WORDS + 1);

   logic             hold_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + CNT_W'(1);

   // flag carried by the word produced in this cycle
   always_comb begin
      if (unstable_i)  flag_o = 1'b1;
      else if (hold_q) flag_o = (cnt_nxt < CNT_W'(CLEAR_WORDS));
      else             flag_o = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hold_q <= 1'b0;
         cnt_q  <= '0;
      end else if (conv_i) begin
         if (unstable_i) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
         end else if (hold_q) begin
            if (cnt_nxt >= CNT_W'(CLEAR_WORDS)) begin
               hold_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_nxt;
            end
         end
      end
   end

   assert_osc_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_i && unstable_i) |=> hold_q);

   assert_osc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_i && !unstable_i && hold_q && cnt_q == CNT_W'(CLEAR_WORDS - 1)) |=> !hold_q);

endmodule

// File: rtl/sro_withdraw.sv
module sro_withdraw #(
   parameter bit FREE_RUN      = 1'b0,
   parameter int WORD_PERIOD   = 1224,
   parameter int WITHDRAW_LEAD = 17
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic conv_i,
   input  logic fresh_i,
   output logic withdraw_o
);

   generate
      if (FREE_RUN) begin : g_timer
         localparam int CNT_W = $clog2(WORD_PERIOD + 1);
         localparam int HIT   = WORD_PERIOD - WITHDRAW_LEAD;
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni)                              cnt_q <= '0;
            else if (conv_i)                          cnt_q <= '0;
            else if (cnt_q != CNT_W'(WORD_PERIOD))    cnt_q <= cnt_q + CNT_W'(1);
         end

         assign withdraw_o = fresh_i && (cnt_q == CNT_W'(HIT));
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = ^{clk_i, rst_ni, conv_i, fresh_i};
         assign withdraw_o    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sro_shifter.sv
module sro_shifter
   import sro_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      cs_ni,
   input  logic      sclk_rise_i,
   input  logic      sclk_fall_i,
   input  logic      cap_i,
   input  sro_word_t word_i,
   input  logic      withdraw_i,
   output logic      sdo_o,
   output logic      fresh_o
);

   localparam int IDX_W = $clog2(WORD_W);

   sro_state_e         st_q;
   sro_word_t          held_q;
   logic [WORD_W-1:0]  shreg_q;
   logic [IDX_W-1:0]   idx_q;
   logic               skip_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         held_q  <= '0;
         shreg_q <= '0;
         idx_q   <= '0;
         skip_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_PEND: begin
               if (cap_i) begin
                  held_q <= word_i;
                  st_q   <= ST_PEND;
               end else if (st_q == ST_PEND && withdraw_i) begin
                  st_q   <= ST_IDLE;
               end else if (st_q == ST_PEND && !cs_ni && sclk_rise_i) begin
                  st_q    <= ST_SHIFT;
                  shreg_q <= held_q;
                  idx_q   <= IDX_W'(WORD_W - 1);
                  skip_q  <= 1'b1;
               end
            end
            ST_SHIFT: begin
               if (cs_ni) begin
                  st_q <= ST_IDLE;
               end else if (withdraw_i) begin
                  st_q <= ST_IDLE;
               end else if (sclk_fall_i) begin
                  if (skip_q) begin
                     skip_q <= 1'b0;
                  end else if (idx_q == '0) begin
                     st_q <= ST_IDLE;
                  end else begin
                     idx_q   <= idx_q - IDX_W'(1);
                     shreg_q <= shreg_q << 1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sdo_o   = (st_q == ST_SHIFT) ? shreg_q[WORD_W-1] : 1'b1;
   assign fresh_o = (st_q == ST_PEND) ||
                    (st_q == ST_SHIFT && idx_q == IDX_W'(WORD_W - 1));

   assert_drop_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q == ST_SHIFT) |-> ($past(sclk_rise_i) && $past(!cs_ni)));

   assert_line_high_after_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SHIFT && sclk_fall_i && !skip_q && idx_q == '0 && !cs_ni)
      |=> (sdo_o && st_q != ST_SHIFT));

   assert_hold_during_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SHIFT) |=> $stable(held_q));

   assert_abort_on_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_ni |=> (st_q != ST_SHIFT));

endmodule

// File: rtl/adc_result_sport.sv
module adc_result_sport
   import sro_pkg::*;
#(
   parameter int SAMPLE_W        = 20,
   parameter int OSC_CLEAR_WORDS = 4,
   parameter bit FREE_RUN        = 1'b0,
   parameter int WORD_PERIOD     = 1224,
   parameter int WITHDRAW_LEAD   = 17
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sclk_i,
   input  logic                cs_ni,
   input  logic                conv_done_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                ovr_pos_i,
   input  logic                ovr_neg_i,
   input  logic                mod_unstable_i,
   output logic                sdo_o,
   output logic                sdo_oe_o
);

   generate
      if (SAMPLE_W != 16 && SAMPLE_W != 20) begin : g_bad_width
         $fatal(1, "SAMPLE_W must be 16 or 20");
      end
      if (OSC_CLEAR_WORDS < 1) begin : g_bad_clear
         $fatal(1, "OSC_CLEAR_WORDS must be at least 1");
      end
      if (WITHDRAW_LEAD < 1 || WITHDRAW_LEAD >= WORD_PERIOD) begin : g_bad_lead
         $fatal(1, "WITHDRAW_LEAD must lie inside the word period");
      end
   endgenerate

   logic      sclk_rise, sclk_fall;
   logic      osc_flag;
   logic      withdraw;
   logic      fresh;
   sro_word_t word;

   sro_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sclk_i),
      .rise_o (sclk_rise),
      .fall_o (sclk_fall)
   );

   sro_osc_track #(.CLEAR_WORDS(OSC_CLEAR_WORDS)) u_osc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .conv_i     (conv_done_i),
      .unstable_i (mod_unstable_i),
      .flag_o     (osc_flag)
   );

   sro_word_fmt #(.SAMPLE_W(SAMPLE_W)) u_fmt (
      .sample_i   (sample_i),
      .ovr_pos_i  (ovr_pos_i),
      .ovr_neg_i  (ovr_neg_i),
      .osc_flag_i (osc_flag),
      .word_o     (word)
   );

   sro_withdraw #(
      .FREE_RUN      (FREE_RUN),
      .WORD_PERIOD   (WORD_PERIOD),
      .WITHDRAW_LEAD (WITHDRAW_LEAD)
   ) u_wd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .conv_i     (conv_done_i),
      .fresh_i    (fresh),
      .withdraw_o (withdraw)
   );

   sro_shifter u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_ni       (cs_ni),
      .sclk_rise_i (sclk_rise),
      .sclk_fall_i (sclk_fall),
      .cap_i       (conv_done_i),
      .word_i      (word),
      .withdraw_i  (withdraw),
      .sdo_o       (sdo_o),
      .fresh_o     (fresh)
   );

   assign sdo_oe_o = ~cs_ni;

endmodule

// File: tb/sim_adc_result_sport.sv
module sim_adc_result_sport;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        conv_done = 1'b0;
   logic [19:0] sample = '0;
   logic        ovr_pos = 1'b0, ovr_neg = 1'b0, osc_bad = 1'b0;
   logic        sdo, sdo_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   adc_result_sport #(
      .SAMPLE_W(20), .OSC_CLEAR_WORDS(4), .FREE_RUN(1'b1),
      .WORD_PERIOD(64), .WITHDRAW_LEAD(17)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
      .conv_done_i(conv_done), .sample_i(sample), .ovr_pos_i(ovr_pos),
      .ovr_neg_i(ovr_neg), .mod_unstable_i(osc_bad),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   // {sample, pos, neg, expected word}
   localparam logic [45:0] VEC [0:7] = '{
      {20'h12345, 1'b0, 1'b0, 24'h012345},
      {20'hFFFFF, 1'b0, 1'b0, 24'h0FFFFF},
      {20'h80001, 1'b0, 1'b0, 24'h080001},
      {20'h00000, 1'b0, 1'b0, 24'h000000},
      {20'h12345, 1'b1, 1'b0, 24'h47FFFF},
      {20'h00001, 1'b0, 1'b1, 24'h480000},
      {20'h5A5A5, 1'b0, 1'b0, 24'h05A5A5},
      {20'h7FFFF, 1'b0, 1'b0, 24'h07FFFF}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic convert(input logic [19:0] s, input logic p, input logic n, input logic o);
      sample = s; ovr_pos = p; ovr_neg = n; osc_bad = o; conv_done = 1'b1;
      tick(1);
      conv_done = 1'b0; ovr_pos = 1'b0; ovr_neg = 1'b0; osc_bad = 1'b0;
   endtask

   // ann: line after the announcing rise; tail: line after the last fall
   task automatic read_word(output logic ann, output logic [23:0] w, output logic tail,
                            input int inject_at, input int abort_at);
      w = '0; tail = 1'b0;
      sclk = 1'b1; tick(4);
      ann = sdo;
      sclk = 1'b0; tick(4);
      for (int i = 23; i >= 0; i--) begin
         if (i == abort_at) begin
            cs_n = 1'b1; tick(2);
            return;
         end
         if (i == inject_at) convert(20'hABCDE, 1'b0, 1'b0, 1'b0);
         w[i] = sdo;
         sclk = 1'b1; tick(4);
         sclk = 1'b0; tick(4);
      end
      tail = sdo;
   endtask

   task automatic probe_rise(output logic lvl);
      sclk = 1'b1; tick(4);
      lvl = sdo;
      sclk = 1'b0; tick(4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic        ann, tail, lvl;
      logic [23:0] w;

      tick(5); rst_n = 1'b1; tick(2);
      chk("R1 released while deselected", {23'd0, sdo_oe}, 24'd0);
      cs_n = 1'b0; tick(2);
      chk("R1 driven when selected", {23'd0, sdo_oe}, 24'd1);
      chk("R1 idle line high", {23'd0, sdo}, 24'd1);

      // R2: no drop without a rising serial edge
      convert(20'h00abc, 1'b0, 1'b0, 1'b0);
      tick(6);
      chk("R2 stays high without rise", {23'd0, sdo}, 24'd1);
      read_word(ann, w, tail, -1, -1);
      chk("R2 drop on rise", {23'd0, ann}, 24'd0);
      chk("R3 word after delayed read", w, 24'h000abc);

      // table walk: R3 R4 R5 R6 R8
      foreach (VEC[k]) begin
         convert(VEC[k][45:26], VEC[k][25], VEC[k][24], 1'b0);
         read_word(ann, w, tail, -1, -1);
         chk("R2 ready low", {23'd0, ann}, 24'd0);
         chk("R3 R4 R5 R6 vector word", w, VEC[k][23:0]);
         chk("R8 line high after word", {23'd0, tail}, 24'd1);
      end
      tick(10);
      chk("R8 stays high with no new word", {23'd0, sdo}, 24'd1);

      // R1: deselect while a word waits keeps the word
      convert(20'h31415, 1'b0, 1'b0, 1'b0);
      cs_n = 1'b1; tick(2);
      chk("R1 released with word waiting", {23'd0, sdo_oe}, 24'd0);
      cs_n = 1'b0; tick(1);
      read_word(ann, w, tail, -1, -1);
      chk("R1 waiting word survives deselect", w, 24'h031415);

      // R11: unread word replaced
      convert(20'h11111, 1'b0, 1'b0, 1'b0);
      tick(2);
      convert(20'h22222, 1'b0, 1'b0, 1'b0);
      read_word(ann, w, tail, -1, -1);
      chk("R11 newer word replaces waiting one", w, 24'h022222);

      // R9: conversion during read dropped
      convert(20'h33333, 1'b0, 1'b0, 1'b0);
      read_word(ann, w, tail, 10, -1);
      chk("R9 word unchanged by mid-read conversion", w, 24'h033333);
      probe_rise(lvl);
      chk("R9 dropped conversion not waiting", {23'd0, lvl}, 24'd1);

      // R10: deselect mid-read discards
      convert(20'h44444, 1'b0, 1'b0, 1'b0);
      read_word(ann, w, tail, -1, 12);
      cs_n = 1'b0; tick(2);
      probe_rise(lvl);
      chk("R10 aborted word discarded", {23'd0, lvl}, 24'd1);
      convert(20'h55555, 1'b0, 1'b0, 1'b0);
      read_word(ann, w, tail, -1, -1);
      chk("R10 next conversion readable", w, 24'h055555);

      // R7: oscillation flag hold
      convert(20'h00010, 1'b0, 1'b0, 1'b1);
      read_word(ann, w, tail, -1, -1);
      chk("R7 flag set on unstable", w, 24'h200010);
      for (int s = 1; s <= 4; s++) begin
         convert(20'h00010, 1'b0, 1'b0, 1'b0);
         read_word(ann, w, tail, -1, -1);
         chk("R7 flag after stable words", w, (s < 4) ? 24'h200010 : 24'h000010);
      end

      // R12: withdraw of a waiting word in the free-running variant
      convert(20'h66666, 1'b0, 1'b0, 1'b0);
      sclk = 1'b1; tick(4);
      chk("R12 announced", {23'd0, sdo}, 24'd0);
      tick(40);
      chk("R12 still low before withdraw point", {23'd0, sdo}, 24'd0);
      tick(5);
      chk("R12 withdrawn before next word", {23'd0, sdo}, 24'd1);
      sclk = 1'b0; tick(4);
      convert(20'h77777, 1'b0, 1'b0, 1'b0);
      sclk = 1'b1; tick(4);
      chk("R12 falls again on next word", {23'd0, sdo}, 24'd0);
      sclk = 1'b0; cs_n = 1'b1; tick(4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule